// File: doc/BRIEF.md
# Shared DRAM Time-Slot Controller

This block lets a CPU and an internal video/sound scan engine share one DRAM by giving each a fixed, alternating turn. Time is cut into slots of `SLOT_CYCLES` clocks. Slots alternate strictly between the CPU and the scan engine, and the first slot after reset belongs to the CPU. Inside every slot the block drives the select line of the external row/column address multiplexer and the RAS and CAS strobes in a fixed order.

A CPU transfer can start only at the first phase of a CPU slot. Its acknowledge is asserted once the slot ends, and the CPU waits until then. An expansion card can take over acknowledge generation. While the card's override input is low, the block stops driving acknowledge, and any CPU DRAM access already under way is cancelled. The scan engine keeps its own slots in every case.

With the default parameters the block clock equals the CPU clock: `SLOT_CYCLES=4`, `RAS_PH=1`, `COL_PH=2`, `CAS_PH=3` and `STROBE_LOW=1`. The turn output is therefore a square wave at one eighth of that clock.

Top module: `dram_slot_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block at phase 0 of a CPU slot. In that state `cpu_slot`=1, `dram_ras`=1, `dram_cas`=1, `addr_col_sel`=0 and `cpu_ack_n`=1.
- R2: `cpu_slot` is 1 for 4 clocks and then 0 for 4 clocks, repeating. Phases are counted 0..3 within each slot.
- R3: `addr_col_sel` is 0 (row address) in phases 0 and 1 and 1 (column address) in phases 2 and 3, in every slot.
- R4: In every scan slot `dram_ras` is low in phases 1 to 3, `dram_cas` is low in phase 3, and `scan_load` is 1 in phase 3 only. This holds whatever the level of `card_ack_n`.
- R5: A CPU request is `cpu_as_n`=0 together with `cpu_dram_sel`=1. A request present during phase 0 of a CPU slot starts an access. That access drives `dram_ras` low in phases 1 to 3 and `dram_cas` low in phase 3, and both strobes are released when the slot ends.
- R6: After a completed access, `cpu_ack_n` goes low in the first cycle after the CPU slot ends. It stays low while `cpu_as_n` stays low, and the held request does not start a second access.
- R7: `cpu_ack_n` returns to 1 in the same cycle that `cpu_as_n` goes to 1.
- R8: A request that first appears during a scan slot gets no acknowledge until it has been served in the next CPU slot.
- R9: While `card_ack_n`=0, `cpu_ack_oe` is 0 and the acknowledge output is left undriven.
- R10: If `card_ack_n` goes low during a CPU access, RAS and CAS are released in that same cycle and no acknowledge follows. No new access starts until `cpu_as_n` has returned high.
- R11: In a CPU slot with no request, `dram_ras` and `dram_cas` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_dram_sel | input | 1 | Current CPU address decodes to DRAM |
| card_ack_n | input | 1 | Expansion override, active low: the card generates acknowledge |
| cpu_slot | output | 1 | Turn signal, 1 = CPU slot, 0 = scan slot |
| addr_col_sel | output | 1 | Address multiplexer select, 0 = row, 1 = column |
| dram_ras | output | 1 | Row address strobe (active low by default) |
| dram_cas | output | 1 | Column address strobe (active low by default) |
| scan_load | output | 1 | Scan engine data-capture pulse in the last phase of its slot |
| cpu_ack_n | output | 1 | CPU data-transfer acknowledge, active low |
| cpu_ack_oe | output | 1 | Drive enable for `cpu_ack_n`; 0 = high impedance |

## Verification
A wrong phase counter or turn bit shows up within a single slot. The strobes, the mux select or `scan_load` appear one phase early or late, or `cpu_slot` holds for a wrong number of clocks. A corrupted CPU-access state shows up within one slot as missing or extra RAS/CAS in a CPU slot. It also shows up in the first cycle after the slot as an acknowledge that is missing, early, or still held after the override. A stale cancel or acknowledge flag shows up at the next CPU slot, as a request that is served twice or never restarted.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

   typedef enum logic {
      OWN_CPU  = 1'b0,
      OWN_SCAN = 1'b1
   } slot_owner_e;

   function automatic int unsigned phase_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dram_slot_timer.sv
module dram_slot_timer
   import dram_slot_pkg::*;
#(
   parameter int unsigned SLOT_CYCLES = 4,
   localparam int unsigned PW = phase_bits(SLOT_CYCLES)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] phase,
   output slot_owner_e   owner,
   output logic          slot_first,
   output logic          slot_last
);

   localparam logic [PW-1:0] LAST_PH = PW'(SLOT_CYCLES - 1);
   localparam logic [PW-1:0] ONE     = PW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         owner <= OWN_CPU;
      end else if (phase == LAST_PH) begin
         phase <= '0;
         owner <= (owner == OWN_CPU) ? OWN_SCAN : OWN_CPU;
      end else begin
         phase <= phase + ONE;
      end
   end

   assign slot_first = (phase == '0);
   assign slot_last  = (phase == LAST_PH);

endmodule

// File: rtl/dram_cpu_access.sv
module dram_cpu_access
   import dram_slot_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  slot_owner_e owner,
   input  logic        slot_first,
   input  logic        slot_last,
   input  logic        as_n,
   input  logic        dram_sel,
   input  logic        ovr_n,
   output logic        cpu_busy,
   output logic        ack_hold
);

   logic active_q;
   logic ack_q;
   logic card_q;
   logic req;
   logic start;

   assign req   = !as_n && dram_sel;
   assign start = (owner == OWN_CPU) && slot_first && req && ovr_n
                  && !ack_q && !card_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         ack_q    <= 1'b0;
         card_q   <= 1'b0;
      end else begin
         if (active_q) begin
            if (as_n || !ovr_n) begin
               active_q <= 1'b0;
               card_q   <= 1'b1;
            end else if (slot_last) begin
               active_q <= 1'b0;
               ack_q    <= 1'b1;
            end
         end else if (start) begin
            active_q <= 1'b1;
         end else if (req && !ovr_n) begin
            card_q <= 1'b1;
         end
         if (as_n) begin
            ack_q  <= 1'b0;
            card_q <= 1'b0;
         end
      end
   end

   assign cpu_busy = active_q && ovr_n;
   assign ack_hold = ack_q;

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
   import dram_slot_pkg::*;
#(
   parameter int unsigned SLOT_CYCLES = 4,
   parameter int unsigned RAS_PH      = 1,
   parameter int unsigned COL_PH      = 2,
   parameter int unsigned CAS_PH      = 3,
   parameter bit          STROBE_LOW  = 1'b1,
   localparam int unsigned PW = phase_bits(SLOT_CYCLES)
) (
   input  logic [PW-1:0] phase,
   input  slot_owner_e   owner,
   input  logic          cpu_busy,
   output logic          ras_o,
   output logic          cas_o,
   output logic          col_sel,
   output logic          scan_load
);

   localparam logic [PW-1:0] RAS_P  = PW'(RAS_PH);
   localparam logic [PW-1:0] COL_P  = PW'(COL_PH);
   localparam logic [PW-1:0] CAS_P  = PW'(CAS_PH);
   localparam logic [PW-1:0] LAST_P = PW'(SLOT_CYCLES - 1);

   logic busy;
   logic ras_on;
   logic cas_on;

   assign busy      = (owner == OWN_SCAN) || cpu_busy;
   assign ras_on    = busy && (phase >= RAS_P);
   assign cas_on    = busy && (phase >= CAS_P);
   assign col_sel   = (phase >= COL_P);
   assign scan_load = (owner == OWN_SCAN) && (phase == LAST_P);

   generate
      if (STROBE_LOW) begin : g_low
         assign ras_o = !ras_on;
         assign cas_o = !cas_on;
      end else begin : g_high
         assign ras_o = ras_on;
         assign cas_o = cas_on;
      end
   endgenerate

endmodule

// File: rtl/dram_slot_ctrl.sv
module dram_slot_ctrl
   import dram_slot_pkg::*;
#(
   parameter int unsigned SLOT_CYCLES = 4,
   parameter int unsigned RAS_PH      = 1,
   parameter int unsigned COL_PH      = 2,
   parameter int unsigned CAS_PH      = 3,
   parameter bit          STROBE_LOW  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic cpu_as_n,
   input  logic cpu_dram_sel,
   input  logic card_ack_n,
   output logic cpu_slot,
   output logic addr_col_sel,
   output logic dram_ras,
   output logic dram_cas,
   output logic scan_load,
   output logic cpu_ack_n,
   output logic cpu_ack_oe
);

   localparam int unsigned PW = phase_bits(SLOT_CYCLES);

   generate
      if (!(RAS_PH > 0 && RAS_PH < COL_PH && COL_PH < CAS_PH
            && CAS_PH < SLOT_CYCLES)) begin : g_bad_phases
         $error("phase order must be 0 < RAS_PH < COL_PH < CAS_PH < SLOT_CYCLES");
      end
   endgenerate

   logic [PW-1:0] phase;
   slot_owner_e   owner;
   logic          slot_first;
   logic          slot_last;
   logic          cpu_busy;
   logic          ack_hold;

   dram_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .phase      (phase),
      .owner      (owner),
      .slot_first (slot_first),
      .slot_last  (slot_last)
   );

   dram_cpu_access u_cpu (
      .clk        (clk),
      .rst        (rst),
      .owner      (owner),
      .slot_first (slot_first),
      .slot_last  (slot_last),
      .as_n       (cpu_as_n),
      .dram_sel   (cpu_dram_sel),
      .ovr_n      (card_ack_n),
      .cpu_busy   (cpu_busy),
      .ack_hold   (ack_hold)
   );

   dram_strobe_gen #(
      .SLOT_CYCLES (SLOT_CYCLES),
      .RAS_PH      (RAS_PH),
      .COL_PH      (COL_PH),
      .CAS_PH      (CAS_PH),
      .STROBE_LOW  (STROBE_LOW)
   ) u_strobe (
      .phase     (phase),
      .owner     (owner),
      .cpu_busy  (cpu_busy),
      .ras_o     (dram_ras),
      .cas_o     (dram_cas),
      .col_sel   (addr_col_sel),
      .scan_load (scan_load)
   );

   assign cpu_slot   = (owner == OWN_CPU);
   assign cpu_ack_n  = !(ack_hold && !cpu_as_n);
   assign cpu_ack_oe = card_ack_n;

endmodule

// File: rtl/dram_slot_ctrl_chk.sv
module dram_slot_ctrl_chk #(
   parameter int unsigned SLOT_CYCLES = 4,
   parameter int unsigned RAS_PH      = 1,
   parameter bit          STROBE_LOW  = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic cpu_as_n,
   input logic card_ack_n,
   input logic cpu_slot,
   input logic addr_col_sel,
   input logic dram_ras,
   input logic dram_cas,
   input logic cpu_ack_n,
   input logic cpu_ack_oe
);

   int unsigned run;
   logic ras_on;
   logic cas_on;

   assign ras_on = STROBE_LOW ? !dram_ras : dram_ras;
   assign cas_on = STROBE_LOW ? !dram_cas : dram_cas;

   always_ff @(posedge clk) begin
      if (rst) run <= 0;
      else     run <= (run == SLOT_CYCLES - 1) ? 0 : run + 1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cpu_slot && !ras_on && !cas_on && !addr_col_sel && cpu_ack_n)); // R1
   AST_TURN_FLIP: assert property (@(posedge clk) disable iff (rst)
      (run == SLOT_CYCLES - 1) |=> (cpu_slot != $past(cpu_slot))); // R2
   AST_TURN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (run != SLOT_CYCLES - 1) |=> $stable(cpu_slot)); // R2
   AST_CAS_ON_COLUMN: assert property (@(posedge clk) disable iff (rst)
      cas_on |-> (addr_col_sel && ras_on)); // R3
   AST_SCAN_RAS: assert property (@(posedge clk) disable iff (rst)
      (!cpu_slot && run >= RAS_PH) |-> ras_on); // R4
   AST_ACK_NEEDS_AS: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack_oe && !cpu_ack_n) |-> !cpu_as_n); // R7
   AST_OVERRIDE_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (cpu_slot && !card_ack_n) |-> (!ras_on && !cas_on)); // R10

endmodule

bind dram_slot_ctrl dram_slot_ctrl_chk #(
   .SLOT_CYCLES (SLOT_CYCLES),
   .RAS_PH      (RAS_PH),
   .STROBE_LOW  (STROBE_LOW)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cpu_as_n     (cpu_as_n),
   .card_ack_n   (card_ack_n),
   .cpu_slot     (cpu_slot),
   .addr_col_sel (addr_col_sel),
   .dram_ras     (dram_ras),
   .dram_cas     (dram_cas),
   .cpu_ack_n    (cpu_ack_n),
   .cpu_ack_oe   (cpu_ack_oe)
);

// File: tb/dram_slot_ctrl_test.sv
`timescale 1ns/100ps
module dram_slot_ctrl_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cpu_as_n = 1'b1;
   logic cpu_dram_sel = 1'b0;
   logic card_ack_n = 1'b1;
   logic cpu_slot, addr_col_sel, dram_ras, dram_cas, scan_load, cpu_ack_n, cpu_ack_oe;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   dram_slot_ctrl uut (
      .clk          (clk),
      .rst          (rst),
      .cpu_as_n     (cpu_as_n),
      .cpu_dram_sel (cpu_dram_sel),
      .card_ack_n   (card_ack_n),
      .cpu_slot     (cpu_slot),
      .addr_col_sel (addr_col_sel),
      .dram_ras     (dram_ras),
      .dram_cas     (dram_cas),
      .scan_load    (scan_load),
      .cpu_ack_n    (cpu_ack_n),
      .cpu_ack_oe   (cpu_ack_oe)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   function automatic bit exp_cpu();
      return ((cyc / 4) % 2) == 0;
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s at cyc %0d: actual=%b expected=%b", req, what, cyc, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic go_to(input bit cpu, input int ph);
      do step(); while (!(exp_cpu() == cpu && (cyc % 4) == ph));
   endtask

   task automatic idle_inputs();
      cpu_as_n = 1'b1; cpu_dram_sel = 1'b0; card_ack_n = 1'b1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(); step();
      rst = 1'b0;
      #0.1;
      chk("R1", "cpu_slot", cpu_slot, 1'b1);
      chk("R1", "ras", dram_ras, 1'b1);
      chk("R1", "cas", dram_cas, 1'b1);
      chk("R1", "col_sel", addr_col_sel, 1'b0);
      chk("R1", "ack_n", cpu_ack_n, 1'b1);
   endtask

   task automatic t_turn();
      for (int i = 0; i < 16; i++) begin
         step();
         chk("R2", "cpu_slot", cpu_slot, exp_cpu());
      end
   endtask

   task automatic t_idle_slots();
      go_to(1'b1, 0);
      for (int ph = 0; ph < 4; ph++) begin
         chk("R11", "ras idle cpu", dram_ras, 1'b1);
         chk("R11", "cas idle cpu", dram_cas, 1'b1);
         chk("R3", "col_sel cpu", addr_col_sel, logic'(ph >= 2));
         step();
      end
      for (int ph = 0; ph < 4; ph++) begin
         chk("R4", "ras scan", dram_ras, logic'(ph < 1));
         chk("R4", "cas scan", dram_cas, logic'(ph != 3));
         chk("R4", "scan_load", scan_load, logic'(ph == 3));
         chk("R3", "col_sel scan", addr_col_sel, logic'(ph >= 2));
         step();
      end
   endtask

   task automatic t_cpu_access();
      go_to(1'b1, 0);
      cpu_as_n = 1'b0; cpu_dram_sel = 1'b1;
      #1;
      chk("R5", "ras p0", dram_ras, 1'b1);
      step();
      chk("R5", "ras p1", dram_ras, 1'b0);
      chk("R5", "cas p1", dram_cas, 1'b1);
      chk("R3", "col p1", addr_col_sel, 1'b0);
      step();
      chk("R3", "col p2", addr_col_sel, 1'b1);
      chk("R5", "cas p2", dram_cas, 1'b1);
      step();
      chk("R5", "cas p3", dram_cas, 1'b0);
      chk("R6", "ack before end", cpu_ack_n, 1'b1);
      step();
      chk("R6", "ack after slot", cpu_ack_n, 1'b0);
      chk("R5", "cas released", dram_cas, 1'b1);
      go_to(1'b1, 1);
      chk("R6", "ack held", cpu_ack_n, 1'b0);
      chk("R6", "no second access", dram_ras, 1'b1);
      cpu_as_n = 1'b1; cpu_dram_sel = 1'b0;
      #1;
      chk("R7", "ack drop with AS", cpu_ack_n, 1'b1);
      step();
      chk("R7", "ack stays released", cpu_ack_n, 1'b1);
   endtask

   task automatic t_scan_slot_request();
      go_to(1'b0, 1);
      cpu_as_n = 1'b0; cpu_dram_sel = 1'b1;
      #1;
      chk("R8", "ack in scan slot", cpu_ack_n, 1'b1);
      go_to(1'b1, 0);
      chk("R8", "ack at cpu p0", cpu_ack_n, 1'b1);
      step();
      chk("R8", "served ras", dram_ras, 1'b0);
      go_to(1'b0, 0);
      chk("R8", "ack after service", cpu_ack_n, 1'b0);
      idle_inputs();
      step();
   endtask

   task automatic t_override_idle();
      go_to(1'b0, 3);
      card_ack_n = 1'b0; cpu_as_n = 1'b0; cpu_dram_sel = 1'b1;
      #1;
      chk("R9", "ack_oe", cpu_ack_oe, 1'b0);
      for (int ph = 1; ph < 4; ph++) begin
         go_to(1'b1, ph);
         chk("R10", "no cpu ras", dram_ras, 1'b1);
      end
      go_to(1'b0, 2);
      chk("R4", "scan ras under override", dram_ras, 1'b0);
      card_ack_n = 1'b1;
      go_to(1'b1, 1);
      chk("R10", "no restart while AS held", dram_ras, 1'b1);
      idle_inputs();
      step();
   endtask

   task automatic t_override_abort();
      go_to(1'b1, 0);
      cpu_as_n = 1'b0; cpu_dram_sel = 1'b1;
      step();
      chk("R5", "ras before abort", dram_ras, 1'b0);
      step();
      card_ack_n = 1'b0;
      #1;
      chk("R10", "ras cut", dram_ras, 1'b1);
      chk("R10", "cas cut", dram_cas, 1'b1);
      chk("R9", "ack_oe off", cpu_ack_oe, 1'b0);
      step();
      chk("R10", "ras stays off", dram_ras, 1'b1);
      go_to(1'b0, 3);
      chk("R4", "scan cas under override", dram_cas, 1'b0);
      card_ack_n = 1'b1;
      go_to(1'b1, 2);
      chk("R10", "aborted access not restarted", dram_ras, 1'b1);
      go_to(1'b0, 0);
      chk("R10", "no ack after abort", cpu_ack_n, 1'b1);
      idle_inputs();
      step();
   endtask

   task automatic t_reset_mid_access();
      go_to(1'b1, 0);
      cpu_as_n = 1'b0; cpu_dram_sel = 1'b1;
      go_to(1'b1, 2);
      rst = 1'b1;
      step();
      rst = 1'b0;
      #0.1;
      chk("R1", "slot after mid reset", cpu_slot, 1'b1);
      chk("R1", "ras after mid reset", dram_ras, 1'b1);
      chk("R1", "col after mid reset", addr_col_sel, 1'b0);
      chk("R1", "ack after mid reset", cpu_ack_n, 1'b1);
      idle_inputs();
      step();
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_turn();
      t_idle_slots();
      t_cpu_access();
      t_scan_slot_request();
      t_override_idle();
      t_override_abort();
      t_reset_mid_access();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule